// File: doc/BRIEF.md
# Loop-Through Elasticity Buffer

This block lets a node in a ring or daisy-chain pass received characters on to its own transmitter without carrying over the jitter of the recovered receive clock. Decoded 9-bit symbols (a control flag plus a byte) arrive in the receive clock domain. They are written into an eight-entry dual-clock FIFO and read out in the local transmit clock domain, one symbol per character time.

A loop request, qualified by an indication that the link carries 8-bit encoded characters, selects the transmit source. When loop-through is active, received comma characters (control, 0xBC) are dropped at the write side, and the transmitter takes every character from the loop buffer. It sends a comma fill character when the buffer is empty. When loop-through is off, the transmitter draws from the host transmit FIFO through a pop handshake. The host FIFO is never popped during loop-through, so software can preload it. A write that finds the buffer full is lost and raises a sticky overflow flag, which a clear pulse resets.

Top module: `lt_loop_buf`

## Requirements
- R1: After reset, tx_stb, tx_ctrl, tx_data, tx_loop, buf_full and buf_ovf are 0 and buf_empty is 1.
- R2: Loop-through is active only while both loop_req and enc8_mode are high. While it is inactive, rx_valid stores nothing and buf_empty stays 1.
- R3: While loop-through is active, a received comma (rx_ctrl=1, rx_data=8'hBC) is discarded. Every other received symbol is stored, and symbols are read out in arrival order with their control flag.
- R4: While loop-through is active, each char_tick pops the oldest stored symbol. The symbol appears on tx_ctrl/tx_data with tx_stb=1 in the following transmit clock cycle, and host_pop stays 0 regardless of host_valid.
- R5: A char_tick during loop-through with the buffer empty sends the fill symbol tx_ctrl=1, tx_data=8'hBC.
- R6: The buffer holds 8 symbols. buf_full is 1 once 8 unread symbols are stored and returns to 0 after they are read.
- R7: A non-comma write while full is dropped and sets buf_ovf. buf_ovf stays set until an ovf_clr pulse, and a new drop in the same cycle wins over the clear.
- R8: With loop-through inactive, a char_tick with host_valid=1 raises host_pop in the same cycle and sends the host symbol next cycle. With host_valid=0 it sends the fill symbol and host_pop stays 0.
- R9: The transmit source and tx_loop change only at a char_tick. After loop-through ends, the next char_tick takes the preloaded host symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Active-low reset, receive domain |
| rx_valid | input | 1 | A received symbol is present this cycle |
| rx_ctrl | input | 1 | Control flag of the received symbol |
| rx_data | input | 8 | Byte of the received symbol |
| ovf_clr | input | 1 | Pulse that clears the overflow flag |
| buf_full | output | 1 | Buffer full, receive domain |
| buf_ovf | output | 1 | Sticky overflow flag, receive domain |
| tx_clk | input | 1 | Local transmit clock |
| tx_rst_n | input | 1 | Active-low reset, transmit domain |
| loop_req | input | 1 | Request for loop-through retransmission |
| enc8_mode | input | 1 | Link carries 8-bit encoded characters |
| char_tick | input | 1 | One pulse per transmit character time |
| host_valid | input | 1 | Host transmit FIFO has a symbol ready |
| host_ctrl | input | 1 | Control flag of the host symbol |
| host_data | input | 8 | Byte of the host symbol |
| host_pop | output | 1 | Pop strobe to the host transmit FIFO |
| tx_stb | output | 1 | A new transmit symbol is on tx_ctrl/tx_data |
| tx_ctrl | output | 1 | Control flag of the transmit symbol |
| tx_data | output | 8 | Byte of the transmit symbol |
| tx_loop | output | 1 | Last symbol was sourced from the loop buffer |
| buf_empty | output | 1 | Buffer empty, transmit domain |

## Verification
The bench builds the block with its default address width of 3, so the buffer has eight entries and the gray-code full compare that inverts the top two pointer bits is exercised. The small depth lets random bursts reach the exact full point, the dropped ninth write and repeated pointer wrap within a few hundred characters. The two clocks run at unrelated periods, so symbols cross the synchronizers at varying phases.

// File: rtl/lt_pkg.sv
// Shared types and helpers for the loop-through elasticity buffer.
// Assumes a 9-bit symbol: one control flag above one data byte.
package lt_pkg;
    localparam int DW = 8;

    typedef struct packed {
        logic          ctrl;
        logic [DW-1:0] data;
    } sym_t;

    localparam sym_t COMMA = '{ctrl: 1'b1, data: 8'hBC};

    function automatic logic is_comma(input sym_t s);
        return s.ctrl && (s.data == COMMA.data);
    endfunction
endpackage

// File: rtl/lt_sync.sv
// Two-flop synchronizer for a bus of W bits.
// Assumes the bus is a single bit or gray coded, so at most one bit moves at a time.
module lt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the destination clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/lt_wr_side.sv
// Write-side pointer logic: binary and gray write pointers, full flag and
// sticky overflow flag. Assumes AW >= 2 and that rgray_s is already
// synchronized into the write clock domain.
module lt_wr_side #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          ovf_clr,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          ovf
);
    logic [AW:0] wbin;
    logic [AW:0] wbin_nx;

    assign full    = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    assign we      = push && !full;
    assign waddr   = wbin[AW-1:0];
    assign wbin_nx = wbin + 1'b1;

    // Advance the write pointers on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Sticky overflow flag; a drop in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               ovf <= 1'b0;
        else if (push && full)    ovf <= 1'b1;
        else if (ovf_clr)         ovf <= 1'b0;
    end
endmodule

// File: rtl/lt_rd_side.sv
// Read-side pointer logic: binary and gray read pointers and empty flag.
// Assumes wgray_s is already synchronized into the read clock domain.
module lt_rd_side #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic [AW:0]   wgray_s,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty
);
    logic [AW:0] rbin;
    logic [AW:0] rbin_nx;

    assign empty   = (rgray == wgray_s);
    assign raddr   = rbin[AW-1:0];
    assign rbin_nx = rbin + 1'b1;

    // Advance the read pointers when a symbol is taken from a non-empty buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop && !empty) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end
endmodule

// File: rtl/lt_loop_buf.sv
// Loop-through elasticity buffer top. Receive-side symbols are filtered
// (commas dropped) and written into a 2**AW entry dual-clock FIFO. The
// transmit side emits one symbol per char_tick, either from the buffer
// (fill comma when empty) or from the host FIFO handshake.
// Assumes loop_req and enc8_mode change slowly relative to both clocks.
module lt_loop_buf
    import lt_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          rx_valid,
    input  logic          rx_ctrl,
    input  logic [DW-1:0] rx_data,
    input  logic          ovf_clr,
    output logic          buf_full,
    output logic          buf_ovf,
    input  logic          tx_clk,
    input  logic          tx_rst_n,
    input  logic          loop_req,
    input  logic          enc8_mode,
    input  logic          char_tick,
    input  logic          host_valid,
    input  logic          host_ctrl,
    input  logic [DW-1:0] host_data,
    output logic          host_pop,
    output logic          tx_stb,
    output logic          tx_ctrl,
    output logic [DW-1:0] tx_data,
    output logic          tx_loop,
    output logic          buf_empty
);
    localparam int DEPTH = 1 << AW;

    sym_t          mem [DEPTH];
    sym_t          rx_sym;
    sym_t          host_sym;
    sym_t          tx_sym;
    logic          loop_any;
    logic          loop_w;
    logic          loop_t;
    logic          push;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [AW:0]   wgray;
    logic [AW:0]   rgray;
    logic [AW:0]   wgray_s;
    logic [AW:0]   rgray_s;
    logic          pop;

    assign loop_any = loop_req && enc8_mode;
    assign rx_sym   = '{ctrl: rx_ctrl, data: rx_data};
    assign host_sym = '{ctrl: host_ctrl, data: host_data};

    lt_sync #(.W(1)) u_loop_w (.clk(wr_clk), .rst_n(wr_rst_n), .d(loop_any), .q(loop_w));
    lt_sync #(.W(1)) u_loop_t (.clk(tx_clk), .rst_n(tx_rst_n), .d(loop_any), .q(loop_t));
    lt_sync #(.W(AW+1)) u_rg_s (.clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s));
    lt_sync #(.W(AW+1)) u_wg_s (.clk(tx_clk), .rst_n(tx_rst_n), .d(wgray), .q(wgray_s));

    assign push = rx_valid && loop_w && !is_comma(rx_sym);

    lt_wr_side #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .push(push), .ovf_clr(ovf_clr),
        .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
        .full(buf_full), .ovf(buf_ovf)
    );

    // Store an accepted receive symbol.
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= rx_sym;
    end

    assign pop      = char_tick && loop_t;
    assign host_pop = char_tick && !loop_t && host_valid;

    lt_rd_side #(.AW(AW)) u_rd (
        .clk(tx_clk), .rst_n(tx_rst_n), .pop(pop), .wgray_s(wgray_s),
        .raddr(raddr), .rgray(rgray), .empty(buf_empty)
    );

    // Pick the source for this character time and register the outgoing symbol.
    always_ff @(posedge tx_clk) begin
        if (!tx_rst_n) begin
            tx_stb  <= 1'b0;
            tx_loop <= 1'b0;
            tx_sym  <= '0;
        end else begin
            tx_stb <= char_tick;
            if (char_tick) begin
                tx_loop <= loop_t;
                if (loop_t) tx_sym <= buf_empty  ? COMMA : mem[raddr];
                else        tx_sym <= host_valid ? host_sym : COMMA;
            end
        end
    end

    assign tx_ctrl = tx_sym.ctrl;
    assign tx_data = tx_sym.data;
endmodule

// File: rtl/lt_loop_buf_chk.sv
// Assertion checker for lt_loop_buf, attached by bind. Watches pointer,
// flag and handshake behaviour in both clock domains.
module lt_loop_buf_chk #(
    parameter int AW = 3
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          tx_clk,
    input logic          tx_rst_n,
    input logic          rx_valid,
    input logic          rx_ctrl,
    input logic [7:0]    rx_data,
    input logic          ovf_clr,
    input logic          buf_full,
    input logic          buf_ovf,
    input logic          buf_empty,
    input logic          loop_w,
    input logic          loop_t,
    input logic          char_tick,
    input logic          host_valid,
    input logic          host_pop,
    input logic          tx_stb,
    input logic          tx_loop,
    input logic [AW:0]   wgray,
    input logic [AW:0]   rgray
);
    a_r2_no_store_when_off: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !loop_w |=> $stable(wgray));
    a_r6_wr_gray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $onehot0(wgray ^ $past(wgray)));
    a_r7_drop_sets_ovf: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        rx_valid && loop_w && buf_full && !(rx_ctrl && rx_data == 8'hBC) |=> buf_ovf);
    a_r7_ovf_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        buf_ovf && !ovf_clr |=> buf_ovf);
    a_r4_host_held_in_loop: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        loop_t |-> !host_pop);
    a_r8_pop_needs_valid: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        host_pop |-> host_valid && char_tick);
    a_r5_empty_no_read: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        buf_empty |=> $stable(rgray));
    a_r9_mode_at_tick: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        !char_tick |=> $stable(tx_loop));
    a_r4_stb_after_tick: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        char_tick |=> tx_stb);
endmodule

bind lt_loop_buf lt_loop_buf_chk #(.AW(AW)) u_chk (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .tx_clk(tx_clk), .tx_rst_n(tx_rst_n),
    .rx_valid(rx_valid), .rx_ctrl(rx_ctrl), .rx_data(rx_data), .ovf_clr(ovf_clr),
    .buf_full(buf_full), .buf_ovf(buf_ovf), .buf_empty(buf_empty),
    .loop_w(loop_w), .loop_t(loop_t), .char_tick(char_tick),
    .host_valid(host_valid), .host_pop(host_pop), .tx_stb(tx_stb),
    .tx_loop(tx_loop), .wgray(wgray), .rgray(rgray)
);

// File: tb/lt_loop_buf_test.sv
// Bench for lt_loop_buf: directed corners plus seeded random bursts,
// checked against a queue model kept in the bench.
module lt_loop_buf_test;
    logic       wr_clk = 0, tx_clk = 0;
    logic       wr_rst_n = 0, tx_rst_n = 0;
    logic       rx_valid = 0, rx_ctrl = 0, ovf_clr = 0;
    logic [7:0] rx_data = 0;
    logic       loop_req = 0, enc8_mode = 0, char_tick = 0;
    logic       host_valid = 0, host_ctrl = 0;
    logic [7:0] host_data = 0;
    logic       buf_full, buf_ovf, host_pop, tx_stb, tx_ctrl, tx_loop, buf_empty;
    logic [7:0] tx_data;

    int total = 0, bad = 0;
    bit done = 0;
    logic [8:0] q[$];
    localparam logic [8:0] FILL = 9'h1BC;

    always #2.5 tx_clk = ~tx_clk;
    always #3.5 wr_clk = ~wr_clk;

    lt_loop_buf uut (.*);

    function automatic logic comma(input logic [8:0] s);
        return s == FILL;
    endfunction

    function automatic logic [8:0] rand_sym();
        logic [8:0] s;
        s = {1'($urandom % 2), 8'($urandom)};
        if (comma(s)) s = 9'h0BC;
        return s;
    endfunction

    function automatic logic model_active();
        return loop_req && enc8_mode;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rx_put(input logic [8:0] s);
        @(negedge wr_clk);
        {rx_ctrl, rx_data} = s;
        rx_valid = 1;
        @(negedge wr_clk);
        rx_valid = 0;
        if (model_active() && !comma(s) && q.size() < 8) q.push_back(s);
    endtask

    task automatic wait_tx(input int n);
        repeat (n) @(negedge tx_clk);
    endtask

    task automatic tick(input logic [8:0] exp, input logic exp_pop, input logic exp_loop, input string tag);
        logic p;
        @(negedge tx_clk);
        char_tick = 1;
        #1 p = host_pop;
        @(negedge tx_clk);
        char_tick = 0;
        chk(p == exp_pop, tag, 32'(p), 32'(exp_pop));
        chk(tx_stb && {tx_ctrl, tx_data} == exp, tag, {tx_stb, tx_ctrl, tx_data}, {1'b1, exp});
        chk(tx_loop == exp_loop, tag, 32'(tx_loop), 32'(exp_loop));
    endtask

    task automatic drain(input string tag);
        while (q.size() > 0) tick(q.pop_front(), 1'b0, 1'b1, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge tx_clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [8:0] hs;
        void'($urandom(32'd20240611));
        repeat (6) @(negedge tx_clk);
        wr_rst_n = 1; tx_rst_n = 1;
        wait_tx(2);
        // R1 reset state
        chk(!tx_stb && !tx_ctrl && tx_data == 0 && !tx_loop, "R1", {tx_stb, tx_ctrl, tx_data, tx_loop}, 0);
        chk(buf_empty && !buf_full && !buf_ovf, "R1", {buf_empty, buf_full, buf_ovf}, 3'b100);

        // R2 loop off: receive writes not stored; R8 host source
        for (int i = 0; i < 3; i++) rx_put(rand_sym());
        wait_tx(8);
        chk(buf_empty, "R2", 32'(buf_empty), 1);
        hs = rand_sym();
        {host_ctrl, host_data} = hs; host_valid = 1;
        tick(hs, 1'b1, 1'b0, "R8");
        host_valid = 0;
        tick(FILL, 1'b0, 1'b0, "R8");

        // R2 loop requested but stream not 8-bit encoded
        loop_req = 1; enc8_mode = 0;
        wait_tx(8);
        for (int i = 0; i < 2; i++) rx_put(rand_sym());
        wait_tx(8);
        chk(buf_empty, "R2", 32'(buf_empty), 1);
        hs = rand_sym();
        {host_ctrl, host_data} = hs; host_valid = 1;
        tick(hs, 1'b1, 1'b0, "R2");

        // R9 enable applies only at a tick; host preloaded symbol held
        hs = rand_sym();
        {host_ctrl, host_data} = hs;
        enc8_mode = 1;
        wait_tx(10);
        chk(!tx_loop, "R9", 32'(tx_loop), 0);

        // R3 commas dropped, order kept; R4 no host pop
        for (int i = 0; i < 7; i++) begin
            rx_put(FILL);
            rx_put(rand_sym());
        end
        wait_tx(8);
        chk(q.size() == 7, "R3", q.size(), 7);
        drain("R4");
        tick(FILL, 1'b0, 1'b1, "R5");
        chk(buf_empty, "R5", 32'(buf_empty), 1);

        // R6 capacity and full flag; R7 overflow sticky
        for (int i = 0; i < 8; i++) rx_put(rand_sym());
        chk(buf_full, "R6", 32'(buf_full), 1);
        chk(!buf_ovf, "R7", 32'(buf_ovf), 0);
        rx_put(FILL);
        chk(!buf_ovf, "R7", 32'(buf_ovf), 0);
        rx_put(rand_sym());
        chk(buf_ovf, "R7", 32'(buf_ovf), 1);
        wait_tx(6);
        drain("R6");
        repeat (6) @(negedge wr_clk);
        chk(!buf_full, "R6", 32'(buf_full), 0);
        chk(buf_ovf, "R7", 32'(buf_ovf), 1);
        @(negedge wr_clk); ovf_clr = 1;
        @(negedge wr_clk); ovf_clr = 0;
        chk(!buf_ovf, "R7", 32'(buf_ovf), 0);

        // random bursts through the loop
        for (int r = 0; r < 30; r++) begin
            int n = $urandom % 9;
            for (int i = 0; i < n; i++) begin
                if ($urandom % 4 == 0) rx_put(FILL);
                else if (q.size() < 8) rx_put(rand_sym());
            end
            wait_tx(8);
            drain("R3");
            tick(FILL, 1'b0, 1'b1, "R5");
        end

        // R9 leave loop: next tick takes preloaded host symbol
        rx_put(rand_sym());
        loop_req = 0;
        wait_tx(10);
        chk(tx_loop, "R9", 32'(tx_loop), 1);
        tick(hs, 1'b1, 1'b0, "R9");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule